// File: doc/BRIEF.md
# Triggered Digitizer Window Extractor

This block sits behind one 8-bit digitizer channel that delivers a sample on every clock. It writes the stream into a circular history without pause, so the last few microseconds of samples are always available. A first-level trigger decision comes some time after the pulse that caused it. When the trigger arrives, the block reaches back into the history by a programmed latency and reads out a fixed window of samples.

Each trigger is queued together with its start address, a 16-bit timestamp and the output mode in force at that moment. Queuing means capture never blocks. An extractor takes queued triggers one at a time. In reduced mode it condenses the window into one record that holds the pedestal-subtracted energy, the index of the peak sample, the timestamp and a channel identifier. When the energy does not exceed a threshold, it writes an empty-event marker instead. In raw mode it forwards every sample of the window.

Records collect in an output FIFO with a show-ahead read port. A batch flag tells the readout side when enough complete events are stored to be worth a bulk transfer. Triggers that find the queue full are dropped. Each drop is counted and raises a sticky error flag.

Top module: `trig_window_extractor`

## Requirements
- R1: While reset is held and in the first cycle after it is released, rd_valid, batch_ready and trig_err are 0 and drop_count is 0.
- R2: Sample-clock cycles are numbered from 0 at the first rising edge after reset. A trigger seen at cycle k selects the WIN_LEN samples that arrived at cycles k-L to k-L+WIN_LEN-1, where L is cfg_latency, with WIN_LEN <= L. Addresses wrap modulo HIST_DEPTH. The window must be read before the history overwrites it.
- R3: In reduced mode the energy field is the sum over the window of (sample - cfg_ped), with any negative term taken as 0. The field is 13 bits wide (default configuration).
- R4: The peak field of a hit record is the window index (0 to WIN_LEN-1) of the first sample that holds the window's maximum raw value. The timestamp field is k modulo 2^16. The channel field is cfg_chan.
- R5: A reduced-mode event produces exactly one word. If energy > cfg_thr, the word is a hit: bits [43:42]=2, [41:29]=energy, [28:24]=peak, [23:8]=timestamp, [7:0]=channel. Otherwise it is an empty marker: bits [43:42]=3, bits [41:24] zero, and the same timestamp and channel fields.
- R6: A raw-mode event produces WIN_LEN words in window order, with the sample in bits [7:0] and bits [41:8] zero. Bits [43:42] are 0 on every word except the last, which carries 1.
- R7: The mode of an event is the cfg_raw value in the trigger's own cycle. Changing cfg_raw later does not alter events already queued. cfg_ped, cfg_thr and cfg_chan must be held stable while events are pending.
- R8: Triggers are accepted while an earlier window is being extracted or read out. Up to TQ_DEPTH triggers wait behind the one being extracted, and events leave in trigger order. A trigger arriving while the extractor is idle starts extraction on the next cycle.
- R9: A trigger that finds the queue full produces no output, increments drop_count and sets trig_err, which stays set until reset. Ten back-to-back triggers from idle keep the first five and drop the other five.
- R10: batch_ready is 1 exactly when the number of complete events in the output FIFO is at least cfg_group. An event is complete when its final word (code 1, 2 or 3) has been stored. An event stops counting once its final word has been read.
- R11: rd_data is valid while rd_valid is 1, and rd_en pops one word per cycle. rd_en while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_in | input | SAMPLE_W | Digitizer sample, one per clock |
| trig | input | 1 | First-level trigger, one event per high cycle |
| cfg_latency | input | log2(HIST_DEPTH) | Lookback from trigger cycle to window start |
| cfg_raw | input | 1 | 1 = raw window, 0 = reduced record |
| cfg_ped | input | SAMPLE_W | Pedestal subtracted per sample |
| cfg_thr | input | ENERGY_W | Energy threshold for a hit |
| cfg_chan | input | CHAN_W | Channel identifier placed in records |
| cfg_group | input | GRP_W | Events per readout batch |
| rd_en | input | 1 | Pop one output word |
| rd_valid | output | 1 | Output FIFO holds a word |
| rd_data | output | OUT_W | Output word at the FIFO head |
| batch_ready | output | 1 | Stored complete events reach cfg_group |
| trig_err | output | 1 | Sticky trigger-queue overflow flag |
| drop_count | output | DROP_W | Number of dropped triggers |

## Verification
The hardest state to reach is a full trigger queue while the extractor is busy. The stimulus gets there by holding trig high for ten consecutive cycles from idle. Five events must come out and five drops must be counted.

A second burst changes cfg_raw on every trigger cycle while triggers are queued. This shows that the mode travels with each queued trigger rather than being read at extraction time.

The batch flag is taken to its edges in two ways. One run stores exactly cfg_group events and then pops a single word. Another pops a raw event one word short of its end and then pops its final word. Sweeps over latency, pedestal and threshold cover empty and hit records, windows clamped at zero and windows made of flat, tied samples.

// File: rtl/twx_pkg.sv
// Shared types for the triggered window extractor.
// Assumes: output words carry a 2-bit kind code in their top bits.
package twx_pkg;

    typedef enum logic [1:0] {
        KIND_RAW      = 2'd0,
        KIND_RAW_LAST = 2'd1,
        KIND_HIT      = 2'd2,
        KIND_EMPTY    = 2'd3
    } twx_kind_e;

    // True when a word of this kind closes an event.
    function automatic logic kind_ends_event(input logic [1:0] k);
        return k != KIND_RAW;
    endfunction

endpackage

// File: rtl/twx_sync_fifo.sv
// Synchronous FIFO with a show-ahead head word.
// Assumes: DEPTH is a power of two and at least 2. A push while full and
// a pop while empty are ignored. The occupancy is exported so the owner
// can derive full and free space.
module twx_sync_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + AW'(1);
            if (do_pop)  rptr <= rptr + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/twx_history.sv
// Circular sample history written one sample per clock.
// Assumes: DEPTH is a power of two, so the write address wraps naturally.
// The read port is registered: data for rd_addr appears one cycle later.
// The timestamp counts the same edges as the write address.
module twx_history #(
    parameter int SAMPLE_W = 8,
    parameter int DEPTH    = 1024,
    parameter int TS_W     = 16,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [AW-1:0]       rd_addr,
    output logic [AW-1:0]       wr_addr,
    output logic [TS_W-1:0]     tstamp,
    output logic [SAMPLE_W-1:0] rd_data
);

    logic [SAMPLE_W-1:0] mem [DEPTH];

    // Sample store and registered read.
    always_ff @(posedge clk) begin
        if (rst_n) mem[wr_addr] <= sample_in;
        rd_data <= mem[rd_addr];
    end

    // Write position and timestamp advance on every clock out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            tstamp  <= '0;
        end else begin
            wr_addr <= wr_addr + AW'(1);
            tstamp  <= tstamp + TS_W'(1);
        end
    end

endmodule

// File: rtl/twx_extract.sv
// Window extractor: takes one queued trigger at a time, reads WIN_LEN
// history samples on consecutive cycles and emits either raw sample words
// or one reduced hit or empty record.
// Assumes: the history read has one cycle of latency. room_ok guarantees
// space for a whole event before extraction starts, so words are never
// pushed into a full FIFO. The config inputs are stable while events
// are pending.
module twx_extract
    import twx_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int WIN_LEN  = 25,
    parameter int ADDR_W   = 10,
    parameter int TS_W     = 16,
    parameter int CHAN_W   = 8,
    parameter int ENERGY_W = 13,
    parameter int PEAK_W   = 5,
    parameter int OUT_W    = 44
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tq_empty,
    input  logic [ADDR_W-1:0]   tq_start,
    input  logic [TS_W-1:0]     tq_ts,
    input  logic                tq_raw,
    output logic                tq_pop,
    input  logic                room_ok,
    output logic [ADDR_W-1:0]   hist_addr,
    input  logic [SAMPLE_W-1:0] hist_data,
    input  logic [SAMPLE_W-1:0] cfg_ped,
    input  logic [ENERGY_W-1:0] cfg_thr,
    input  logic [CHAN_W-1:0]   cfg_chan,
    output logic                out_push,
    output logic [OUT_W-1:0]    out_word
);

    localparam int RAW_PAD = OUT_W - 2 - SAMPLE_W;

    logic                busy;
    logic [PEAK_W-1:0]   cnt;
    logic [ADDR_W-1:0]   cur_start;
    logic [TS_W-1:0]     cur_ts;
    logic                cur_raw;
    logic                v_d;
    logic [PEAK_W-1:0]   i_d;
    logic [ENERGY_W-1:0] acc;
    logic [SAMPLE_W-1:0] pk_val;
    logic [PEAK_W-1:0]   pk_idx;

    logic                last_d, new_pk;
    logic [ENERGY_W-1:0] contrib, e_nx;
    logic [SAMPLE_W-1:0] pk_val_nx;
    logic [PEAK_W-1:0]   pk_idx_nx;
    logic [1:0]          raw_kind;

    assign tq_pop    = !busy && !tq_empty && room_ok;
    assign hist_addr = cur_start + ADDR_W'(cnt);

    // Sequencer: load a queued trigger, then step through the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            cur_start <= '0;
            cur_ts    <= '0;
            cur_raw   <= 1'b0;
        end else if (!busy) begin
            if (tq_pop) begin
                busy      <= 1'b1;
                cnt       <= '0;
                cur_start <= tq_start;
                cur_ts    <= tq_ts;
                cur_raw   <= tq_raw;
            end
        end else if (cnt == PEAK_W'(WIN_LEN - 1)) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt + PEAK_W'(1);
        end
    end

    // Track which window index the returning read data belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_d <= 1'b0;
            i_d <= '0;
        end else begin
            v_d <= busy;
            i_d <= cnt;
        end
    end

    // Per-sample reduction: clamped pedestal subtraction and first-maximum search.
    always_comb begin
        last_d    = (i_d == PEAK_W'(WIN_LEN - 1));
        contrib   = (hist_data > cfg_ped) ? ENERGY_W'(hist_data - cfg_ped) : ENERGY_W'(0);
        e_nx      = ((i_d == '0) ? ENERGY_W'(0) : acc) + contrib;
        new_pk    = (i_d == '0) || (hist_data > pk_val);
        pk_val_nx = new_pk ? hist_data : pk_val;
        pk_idx_nx = new_pk ? i_d : pk_idx;
    end

    // Running energy and peak registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            pk_val <= '0;
            pk_idx <= '0;
        end else if (v_d) begin
            acc    <= e_nx;
            pk_val <= pk_val_nx;
            pk_idx <= pk_idx_nx;
        end
    end

    // Output word formation for raw samples, hits and empty markers.
    always_comb begin
        raw_kind = last_d ? KIND_RAW_LAST : KIND_RAW;
        out_push = v_d && (cur_raw || last_d);
        if (cur_raw)
            out_word = {raw_kind, {RAW_PAD{1'b0}}, hist_data};
        else if (e_nx > cfg_thr)
            out_word = {KIND_HIT, e_nx, pk_idx_nx, cur_ts, cfg_chan};
        else
            out_word = {KIND_EMPTY, {(ENERGY_W + PEAK_W){1'b0}}, cur_ts, cfg_chan};
    end

endmodule

// File: rtl/trig_window_extractor.sv
// Top of the triggered window extractor. It records samples into a
// circular history and queues each trigger with its lookback start,
// timestamp and mode. It extracts windows, stores the resulting words in
// an output FIFO and raises a batch flag when enough complete events wait.
// Assumes: WIN_LEN <= cfg_latency, and queued windows are read before the
// history wraps over them.
module trig_window_extractor
    import twx_pkg::*;
#(
    parameter int SAMPLE_W   = 8,
    parameter int HIST_DEPTH = 1024,
    parameter int WIN_LEN    = 25,
    parameter int TS_W       = 16,
    parameter int CHAN_W     = 8,
    parameter int TQ_DEPTH   = 4,
    parameter int OF_DEPTH   = 2048,
    parameter int DROP_W     = 16,
    localparam int ADDR_W    = $clog2(HIST_DEPTH),
    localparam int ENERGY_W  = $clog2(WIN_LEN * ((1 << SAMPLE_W) - 1) + 1),
    localparam int PEAK_W    = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1,
    localparam int OUT_W     = 2 + ENERGY_W + PEAK_W + TS_W + CHAN_W,
    localparam int GRP_W     = $clog2(OF_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                trig,
    input  logic [ADDR_W-1:0]   cfg_latency,
    input  logic                cfg_raw,
    input  logic [SAMPLE_W-1:0] cfg_ped,
    input  logic [ENERGY_W-1:0] cfg_thr,
    input  logic [CHAN_W-1:0]   cfg_chan,
    input  logic [GRP_W-1:0]    cfg_group,
    input  logic                rd_en,
    output logic                rd_valid,
    output logic [OUT_W-1:0]    rd_data,
    output logic                batch_ready,
    output logic                trig_err,
    output logic [DROP_W-1:0]   drop_count
);

    localparam int TQ_W  = 1 + TS_W + ADDR_W;
    localparam int TQ_CW = $clog2(TQ_DEPTH + 1);

    logic [ADDR_W-1:0]   wr_addr, hist_addr;
    logic [TS_W-1:0]     tstamp;
    logic [SAMPLE_W-1:0] hist_data;
    logic [TQ_W-1:0]     tq_din, tq_dout;
    logic                tq_empty, tq_pop, tq_full;
    logic [TQ_CW-1:0]    tq_count;
    logic                room_ok, out_push, of_empty;
    logic [OUT_W-1:0]    out_word;
    logic [GRP_W-1:0]    of_count, ev_count;
    logic                ev_inc, ev_dec;

    twx_history #(
        .SAMPLE_W (SAMPLE_W),
        .DEPTH    (HIST_DEPTH),
        .TS_W     (TS_W)
    ) i_history (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_in (sample_in),
        .rd_addr   (hist_addr),
        .wr_addr   (wr_addr),
        .tstamp    (tstamp),
        .rd_data   (hist_data)
    );

    assign tq_din  = {cfg_raw, tstamp, wr_addr - cfg_latency};
    assign tq_full = (tq_count == TQ_CW'(TQ_DEPTH));

    twx_sync_fifo #(
        .W     (TQ_W),
        .DEPTH (TQ_DEPTH)
    ) i_trig_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (trig),
        .din   (tq_din),
        .pop   (tq_pop),
        .dout  (tq_dout),
        .empty (tq_empty),
        .count (tq_count)
    );

    // Overflow accounting for triggers that find the queue full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_err   <= 1'b0;
            drop_count <= '0;
        end else if (trig && tq_full) begin
            trig_err   <= 1'b1;
            drop_count <= drop_count + DROP_W'(1);
        end
    end

    assign room_ok = (of_count <= GRP_W'(OF_DEPTH - WIN_LEN - 1));

    twx_extract #(
        .SAMPLE_W (SAMPLE_W),
        .WIN_LEN  (WIN_LEN),
        .ADDR_W   (ADDR_W),
        .TS_W     (TS_W),
        .CHAN_W   (CHAN_W),
        .ENERGY_W (ENERGY_W),
        .PEAK_W   (PEAK_W),
        .OUT_W    (OUT_W)
    ) i_extract (
        .clk       (clk),
        .rst_n     (rst_n),
        .tq_empty  (tq_empty),
        .tq_start  (tq_dout[ADDR_W-1:0]),
        .tq_ts     (tq_dout[ADDR_W +: TS_W]),
        .tq_raw    (tq_dout[TQ_W-1]),
        .tq_pop    (tq_pop),
        .room_ok   (room_ok),
        .hist_addr (hist_addr),
        .hist_data (hist_data),
        .cfg_ped   (cfg_ped),
        .cfg_thr   (cfg_thr),
        .cfg_chan  (cfg_chan),
        .out_push  (out_push),
        .out_word  (out_word)
    );

    twx_sync_fifo #(
        .W     (OUT_W),
        .DEPTH (OF_DEPTH)
    ) i_out_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (out_push),
        .din   (out_word),
        .pop   (rd_en),
        .dout  (rd_data),
        .empty (of_empty),
        .count (of_count)
    );

    assign rd_valid = !of_empty;
    assign ev_inc   = out_push && kind_ends_event(out_word[OUT_W-1 -: 2]);
    assign ev_dec   = rd_en && !of_empty && kind_ends_event(rd_data[OUT_W-1 -: 2]);

    // Count complete events held in the output FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_count <= '0;
        else        ev_count <= ev_count + GRP_W'(ev_inc) - GRP_W'(ev_dec);
    end

    assign batch_ready = (ev_count >= cfg_group);

endmodule

// File: rtl/twx_checker.sv
// Protocol and state checks for the triggered window extractor, attached
// to the top module by the bind statement at the end of this file.
// Assumes: connected to the top module's ports and internal queue signals.
module twx_checker #(
    parameter int DROP_W   = 16,
    parameter int GRP_W    = 12,
    parameter int OF_DEPTH = 2048
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig,
    input logic              tq_full,
    input logic              tq_empty,
    input logic              tq_pop,
    input logic              out_push,
    input logic [GRP_W-1:0]  of_count,
    input logic              rd_valid,
    input logic              batch_ready,
    input logic              trig_err,
    input logic [DROP_W-1:0] drop_count,
    input logic [GRP_W-1:0]  cfg_group
);

    // R9: the overflow flag never clears without reset.
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_err |=> trig_err);

    // R9: a trigger meeting a full queue raises the flag.
    assert_err_on_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && tq_full) |=> trig_err);

    // R9: the drop counter moves only on a rejected trigger.
    assert_drop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig && tq_full) |=> $stable(drop_count));

    // R8: the extractor takes a trigger only from a non-empty queue.
    assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tq_pop |-> !tq_empty);

    // R8: extraction never pushes a word into a full output FIFO.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_push |-> (of_count != GRP_W'(OF_DEPTH)));

    // R10: a batch cannot be ready while the output FIFO is empty.
    assert_batch_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_group != '0) && !rd_valid) |-> !batch_ready);

endmodule

bind trig_window_extractor twx_checker #(
    .DROP_W   (DROP_W),
    .GRP_W    (GRP_W),
    .OF_DEPTH (OF_DEPTH)
) i_twx_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig        (trig),
    .tq_full     (tq_full),
    .tq_empty    (tq_empty),
    .tq_pop      (tq_pop),
    .out_push    (out_push),
    .of_count    (of_count),
    .rd_valid    (rd_valid),
    .batch_ready (batch_ready),
    .trig_err    (trig_err),
    .drop_count  (drop_count),
    .cfg_group   (cfg_group)
);

// File: tb/test_trig_window_extractor.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps latency, pedestal, threshold and mode over a
// reduced history and output FIFO. Expected words are computed from a
// known sample function of the cycle index.
module test_trig_window_extractor;

    localparam int CLK_PERIOD = 4;
    localparam int HD   = 256;
    localparam int WIN  = 25;
    localparam int OFD  = 128;
    localparam int AW   = 8;
    localparam int EW   = 13;
    localparam int OW   = 44;
    localparam int GW   = 8;

    logic          clk, rst_n;
    logic [7:0]    sample_in;
    logic          trig;
    logic [AW-1:0] cfg_latency;
    logic          cfg_raw;
    logic [7:0]    cfg_ped;
    logic [EW-1:0] cfg_thr;
    logic [7:0]    cfg_chan;
    logic [GW-1:0] cfg_group;
    logic          rd_en;
    logic          rd_valid;
    logic [OW-1:0] rd_data;
    logic          batch_ready;
    logic          trig_err;
    logic [15:0]   drop_count;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [OW-1:0] expq [512];
    int eq_wr = 0;
    int eq_rd = 0;

    trig_window_extractor #(
        .HIST_DEPTH (HD),
        .WIN_LEN    (WIN),
        .OF_DEPTH   (OFD)
    ) i_trig_window_extractor (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_in   (sample_in),
        .trig        (trig),
        .cfg_latency (cfg_latency),
        .cfg_raw     (cfg_raw),
        .cfg_ped     (cfg_ped),
        .cfg_thr     (cfg_thr),
        .cfg_chan    (cfg_chan),
        .cfg_group   (cfg_group),
        .rd_en       (rd_en),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .batch_ready (batch_ready),
        .trig_err    (trig_err),
        .drop_count  (drop_count)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // Sample for cycle n: flat runs of 100 every fourth block of 64, else scrambled.
    function automatic logic [7:0] samp(input int n);
        logic [31:0] x;
        x = 32'(n * 73 + (n >> 2) * 29) ^ 32'(n >> 3);
        if (((n >> 6) & 3) == 0) return 8'd100;
        return x[7:0];
    endfunction

    always @(negedge clk) sample_in = samp(cyc);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Append the words expected for a trigger at cycle k.
    task automatic add_expect(input int k, input bit raw);
        int base, energy, pk_i, pk_v;
        logic [7:0] s;
        base = k - int'(cfg_latency);
        energy = 0; pk_i = 0; pk_v = -1;
        for (int i = 0; i < WIN; i++) begin
            s = samp(base + i);
            if (raw) begin
                expq[eq_wr % 512] = {(i == WIN-1) ? 2'b01 : 2'b00, 34'b0, s};
                eq_wr++;
            end else begin
                if (s > cfg_ped) energy += int'(s) - int'(cfg_ped);
                if (int'(s) > pk_v) begin pk_v = int'(s); pk_i = i; end
            end
        end
        if (!raw) begin
            if (energy > int'(cfg_thr))
                expq[eq_wr % 512] = {2'b10, 13'(energy), 5'(pk_i), 16'(k), cfg_chan};
            else
                expq[eq_wr % 512] = {2'b11, 18'b0, 16'(k), cfg_chan};
            eq_wr++;
        end
    endtask

    // Called at a negedge; raises trig for one cycle with the given mode.
    task automatic fire(input bit raw, input bit keep);
        trig = 1'b1;
        cfg_raw = raw;
        if (keep) add_expect(cyc, raw);
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_word(input string req);
        int t;
        t = 0;
        while (!rd_valid && t < 2000) begin @(negedge clk); t++; end
        chk(req, 64'(rd_data), 64'(expq[eq_rd % 512]));
        eq_rd++;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain(input string req);
        while (eq_rd != eq_wr) pop_word(req);
        chk("R11 empty after drain", 64'(rd_valid), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; trig = 1'b0; rd_en = 1'b0; cfg_raw = 1'b0;
        cfg_latency = 8'd40; cfg_ped = 8'd0; cfg_thr = '0;
        cfg_chan = 8'h5A; cfg_group = 8'd64;
        idle(5);
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        chk("R1 batch_ready", 64'(batch_ready), 64'd0);
        chk("R1 trig_err", 64'(trig_err), 64'd0);
        chk("R1 drop_count", 64'(drop_count), 64'd0);
        rst_n = 1'b1;
        idle(1);
        chk("R1 rd_valid after release", 64'(rd_valid), 64'd0);
        chk("R1 drop_count after release", 64'(drop_count), 64'd0);
        idle(300);

        // R2 R3 R4 R5: reduced records over pedestal, threshold and latency.
        foreach (cfg_ped_vals[pi]) begin
            cfg_ped  = cfg_ped_vals[pi];
            cfg_chan = 8'(8'h30 + pi);
            foreach (thr_vals[ti]) begin
                cfg_thr = thr_vals[ti];
                foreach (lat_vals[li]) begin
                    cfg_latency = lat_vals[li];
                    fire(1'b0, 1'b1);
                    idle(30);
                end
                drain("R2 R3 R4 R5 reduced record");
            end
        end

        // R2 R6: raw windows at several latencies.
        cfg_ped = 8'd0; cfg_thr = '0;
        foreach (raw_lat[li]) begin
            cfg_latency = raw_lat[li];
            fire(1'b1, 1'b1);
            idle(30);
            drain("R2 R6 raw window");
        end

        // R7 R8: back-to-back triggers with the mode changing each cycle.
        cfg_latency = 8'd40; cfg_thr = 13'd1000;
        fire(1'b0, 1'b1);
        fire(1'b1, 1'b1);
        fire(1'b0, 1'b1);
        fire(1'b1, 1'b1);
        cfg_raw = 1'b0;
        drain("R7 R8 per-trigger mode and order");

        // R11: reads of an empty FIFO have no effect.
        rd_en = 1'b1;
        idle(3);
        rd_en = 1'b0;
        chk("R11 rd_valid stays low", 64'(rd_valid), 64'd0);
        fire(1'b0, 1'b1);
        idle(30);
        drain("R11 event intact after empty reads");

        // R9: ten consecutive triggers, five kept.
        for (int i = 0; i < 10; i++) fire(1'b0, i < 5);
        idle(200);
        chk("R9 drop_count", 64'(drop_count), 64'd5);
        chk("R9 trig_err set", 64'(trig_err), 64'd1);
        drain("R9 kept events");
        fire(1'b0, 1'b1);
        idle(30);
        drain("R9 later event");
        chk("R9 drop_count unchanged", 64'(drop_count), 64'd5);
        chk("R9 trig_err sticky", 64'(trig_err), 64'd1);

        // R10: small group of reduced events.
        cfg_group = 8'd3;
        fire(1'b0, 1'b1); idle(40);
        fire(1'b0, 1'b1); idle(40);
        chk("R10 two of three", 64'(batch_ready), 64'd0);
        fire(1'b0, 1'b1); idle(40);
        chk("R10 three of three", 64'(batch_ready), 64'd1);
        pop_word("R10 first word");
        chk("R10 drops after one read", 64'(batch_ready), 64'd0);
        drain("R10 rest");

        // R10 R6: raw events count only on their final word.
        cfg_group = 8'd2;
        fire(1'b1, 1'b1); idle(40);
        chk("R10 one raw event", 64'(batch_ready), 64'd0);
        fire(1'b1, 1'b1); idle(40);
        chk("R10 two raw events", 64'(batch_ready), 64'd1);
        for (int i = 0; i < WIN-1; i++) pop_word("R6 raw words");
        chk("R10 held before last word", 64'(batch_ready), 64'd1);
        pop_word("R6 raw last word");
        chk("R10 cleared after last word", 64'(batch_ready), 64'd0);
        drain("R6 second raw event");

        // R10: full group of 64 reduced events.
        cfg_group = 8'd64;
        for (int i = 0; i < 63; i++) begin fire(1'b0, 1'b1); idle(29); end
        chk("R10 63 of 64", 64'(batch_ready), 64'd0);
        fire(1'b0, 1'b1); idle(30);
        chk("R10 64 of 64", 64'(batch_ready), 64'd1);
        pop_word("R10 group head");
        chk("R10 below group after read", 64'(batch_ready), 64'd0);
        drain("R3 R4 R5 group events");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    logic [7:0]    cfg_ped_vals [3] = '{8'd0, 8'd90, 8'd160};
    logic [EW-1:0] thr_vals     [3] = '{13'd0, 13'd600, 13'd2500};
    logic [AW-1:0] lat_vals     [3] = '{8'd25, 8'd77, 8'd150};
    logic [AW-1:0] raw_lat      [4] = '{8'd25, 8'd26, 8'd100, 8'd200};

endmodule